// File: doc/BRIEF.md
# Gated Clock Fan-Out With Per-Output Stop

This block takes one input clock and distributes it to ten outputs. Each output is a non-inverted copy of the input clock while its enable bit is set. When the bit is cleared, the output is held low. Stopping and restarting are glitch-free: the gate state of each output only changes while the input clock is low, so a high phase is never cut short and no partial pulse appears.

The enable bits come from three configuration bytes. A fixed bit layout assigns the bits to outputs. Only ten bits carry meaning; the other bits are ignored. A global output-enable input controls the pad drivers. When it is low, every output driver is switched off through a per-output drive-enable vector, so the pads float at high impedance. When it is high, every output is driven. The configuration bytes are plain inputs; how they are written is outside this block.

Each enable bit is resynchronised to the input clock on its rising edge. The gate register is then loaded on the falling edge. A change to a configuration bit becomes visible at the outputs from the second rising edge after the change.

Top module: `clkfan_top`

## Requirements
- R1: While its enable bit is 1 and the block is out of reset, an output is high during every high phase of `clkIn` and low during every low phase.
- R2: While its enable bit is 0, an output stays low in both phases of `clkIn`.
- R3: Enable bits map to outputs as follows: `cfgByte0` bits 0..3 drive outputs 0..3; `cfgByte1` bits 4..7 drive outputs 4..7; `cfgByte2` bit 6 drives output 8 and bit 7 drives output 9.
- R4: When `oeIn` is 0, all ten bits of `clkDrive` are 0 (the outputs are high impedance). When `oeIn` is 1, all ten bits are 1.
- R5: While `rstN` is low, all ten outputs are enabled and copy `clkIn`, whatever the configuration bytes hold.
- R6: A gate changes state only while `clkIn` is low, so every high phase of an output lasts the full high phase of `clkIn`. This holds even when an enable bit changes in the middle of a high phase.
- R7: Suppose an enable bit changes while `clkIn` is low before rising edge k. The output keeps its old behaviour through the high phase after edge k. It shows the new behaviour from edge k+1 onward.
- R8: The reserved bits (`cfgByte0` bits 4..7, `cfgByte1` bits 0..3, `cfgByte2` bits 0..5) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Clock to be fanned out |
| rstN | input | 1 | Asynchronous active-low reset; enables all outputs |
| oeIn | input | 1 | Global output enable; 0 puts all outputs at high impedance |
| cfgByte0 | input | 8 | Enable bits for outputs 0..3 (bits 0..3) |
| cfgByte1 | input | 8 | Enable bits for outputs 4..7 (bits 4..7) |
| cfgByte2 | input | 8 | Enable bits for outputs 8 and 9 (bits 6 and 7) |
| clkOut | output | 10 | Gated clock outputs, parked low when stopped |
| clkDrive | output | 10 | Per-output pad drive enable; 0 means high impedance |

## Verification
The bench targets four kinds of error.

- Bit layout: single-bit and mixed patterns catch a swapped or shifted mapping, which would start or stop the wrong output. Patterns that set only reserved bits catch a design that lets those bits gate an output.
- Mid-phase changes: enable bits are changed in the middle of a high phase. A gate that updates on the rising edge or combinationally would truncate that high phase, or raise the output part-way through it.
- Latency: the bench samples the exact high phase before and after the change takes effect. A missing or extra synchroniser stage would shift the output by one cycle.
- Reset: during reset the configuration bytes are held at zero. A design that does not force its enables would then show silent outputs.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  localparam int NUM_OUT   = 10;
  localparam int CFG_BYTES = 3;
  localparam int BYTE_W    = 8;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic [NUM_OUT-1:0] enReq;    // resynchronised enable per output
    logic               driveAll; // pad drive enable for every output
  } gateCtrl_t;

  // Which configuration byte holds the enable for output idx
  function automatic int byteSel(input int idx);
    if (idx < 4)      return 0;
    else if (idx < 8) return 1;
    else              return 2;
  endfunction

  // Which bit inside that byte holds the enable for output idx
  function automatic int bitSel(input int idx);
    if (idx < 8) return idx;
    else         return idx - 2;
  endfunction

endpackage

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
  import clkfan_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic                              clkIn,
  input  logic                              rstN,
  input  logic                              oeIn,
  input  logic [CFG_BYTES-1:0][BYTE_W-1:0]  cfgBytes,
  output gateCtrl_t                         ctrl
);

  logic [NUM_OUT-1:0] mappedEn;
  logic [SYNC_STAGES-1:0][NUM_OUT-1:0] syncQ;

  // Fixed layout: pick each output's bit, leave reserved bits unread
  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_map
    localparam int SEL_BYTE = byteSel(gi);
    localparam int SEL_BIT  = bitSel(gi);
    assign mappedEn[gi] = cfgBytes[SEL_BYTE][SEL_BIT];
  end

  // Rising-edge resync chain; reset value enables everything
  for (genvar gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
    if (gs == 0) begin : g_first
      always_ff @(posedge clkIn or negedge rstN) begin
        if (!rstN) syncQ[gs] <= '1;
        else       syncQ[gs] <= mappedEn;
      end
    end else begin : g_next
      always_ff @(posedge clkIn or negedge rstN) begin
        if (!rstN) syncQ[gs] <= '1;
        else       syncQ[gs] <= syncQ[gs-1];
      end
    end
  end

  assign ctrl.enReq    = syncQ[SYNC_STAGES-1];
  assign ctrl.driveAll = oeIn;

endmodule

// File: rtl/clkfan_gate.sv
module clkfan_gate
  import clkfan_pkg::*;
(
  input  logic               clkIn,
  input  logic               rstN,
  input  gateCtrl_t          ctrl,
  output logic [NUM_OUT-1:0] clkOut,
  output logic [NUM_OUT-1:0] clkDrive
);

  logic [NUM_OUT-1:0] gateEn;

  // Gate state loads on the falling edge: only ever changes while clock is low
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) gateEn <= '1;
    else       gateEn <= ctrl.enReq;
  end

  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
    assign clkOut[gi]   = clkIn & gateEn[gi];
    assign clkDrive[gi] = ctrl.driveAll;

    // R2: a request that was low at the last falling edge keeps the output low
    assert_low_when_stopped_R2: assert property (
      @(negedge clkIn) disable iff (!rstN)
        !$past(ctrl.enReq[gi]) |-> !clkOut[gi]);

    // R6: a request that was high at the last falling edge yields a full high phase
    assert_full_high_R6: assert property (
      @(negedge clkIn) disable iff (!rstN)
        $past(ctrl.enReq[gi]) |-> clkOut[gi]);
  end

  // R7: at each rising edge the gate holds what control requested one edge earlier
  assert_gate_tracks_req_R7: assert property (
    @(posedge clkIn) disable iff (!rstN)
      gateEn == ctrl.enReq);

endmodule

// File: rtl/clkfan_top.sv
module clkfan_top
  import clkfan_pkg::*;
(
  input  logic               clkIn,
  input  logic               rstN,
  input  logic               oeIn,
  input  logic [7:0]         cfgByte0,
  input  logic [7:0]         cfgByte1,
  input  logic [7:0]         cfgByte2,
  output logic [NUM_OUT-1:0] clkOut,
  output logic [NUM_OUT-1:0] clkDrive
);

  gateCtrl_t                        ctrl;
  logic [CFG_BYTES-1:0][BYTE_W-1:0] cfgBytes;

  assign cfgBytes = {cfgByte2, cfgByte1, cfgByte0};

  clkfan_ctrl #(.SYNC_STAGES(1)) u_ctrl (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .oeIn     (oeIn),
    .cfgBytes (cfgBytes),
    .ctrl     (ctrl)
  );

  clkfan_gate u_gate (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .clkOut   (clkOut),
    .clkDrive (clkDrive)
  );

  // R4: the pad drive vector follows the global enable pin
  assert_drive_follows_oe_R4: assert property (
    @(posedge clkIn) disable iff (!rstN)
      clkDrive == {NUM_OUT{oeIn}});

endmodule

// File: tb/clkfan_top_bench.sv
`timescale 1ns/100ps
module clkfan_top_bench;

  logic       clkIn = 1'b0;
  logic       rstN  = 1'b0;
  logic       oeIn  = 1'b1;
  logic [7:0] cfgByte0 = 8'h00, cfgByte1 = 8'h00, cfgByte2 = 8'h00;
  logic [9:0] clkOut, clkDrive;

  int errCount = 0;
  int chkCount = 0;
  bit done = 0;

  clkfan_top u_clkfan_top (
    .clkIn(clkIn), .rstN(rstN), .oeIn(oeIn),
    .cfgByte0(cfgByte0), .cfgByte1(cfgByte1), .cfgByte2(cfgByte2),
    .clkOut(clkOut), .clkDrive(clkDrive)
  );

  always #2 clkIn = ~clkIn;   // 250 MHz

  typedef struct packed {
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] b2;
    logic       oe;
    logic [9:0] expOut;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{8'hFF, 8'hFF, 8'hFF, 1'b1, 10'h3FF},  // R1 all running
    '{8'h00, 8'h00, 8'h00, 1'b1, 10'h000},  // R2 all stopped
    '{8'h0F, 8'hF0, 8'hC0, 1'b1, 10'h3FF},  // R3 only live bits
    '{8'hF0, 8'h0F, 8'h3F, 1'b1, 10'h000},  // R8 only reserved bits
    '{8'h01, 8'h00, 8'h00, 1'b1, 10'h001},  // R3 output 0
    '{8'h00, 8'h10, 8'h00, 1'b1, 10'h010},  // R3 output 4
    '{8'h00, 8'h80, 8'h00, 1'b1, 10'h080},  // R3 output 7
    '{8'h00, 8'h00, 8'h40, 1'b1, 10'h100},  // R3 output 8
    '{8'h00, 8'h00, 8'h80, 1'b1, 10'h200},  // R3 output 9
    '{8'h05, 8'hA0, 8'h80, 1'b1, 10'h2A5},  // R3 mixed
    '{8'hFF, 8'hFF, 8'hFF, 1'b0, 10'h3FF},  // R4 tri-state
    '{8'h0A, 8'h50, 8'h40, 1'b0, 10'h15A}   // R4 tri-state, mixed
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setCfg(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    cfgByte0 = b0; cfgByte1 = b1; cfgByte2 = b2;
  endtask

  initial begin
    // Reset: config zero, outputs must still run (R5)
    @(negedge clkIn); #0.5;
    @(posedge clkIn); #1;
    check("R5 reset high phase", clkOut, 10'h3FF);
    check("R4 drive during reset", clkDrive, 10'h3FF);
    @(negedge clkIn); #1;
    check("R5 reset low phase", clkOut, 10'h000);
    setCfg(8'hFF, 8'hFF, 8'hFF);
    rstN = 1'b1;
    repeat (2) @(posedge clkIn);

    // Vector walk
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clkIn); #0.5;
      setCfg(VECS[v].b0, VECS[v].b1, VECS[v].b2);
      oeIn = VECS[v].oe;
      repeat (2) @(posedge clkIn);
      #1;
      check($sformatf("R1/R2/R3/R8 vec%0d high", v), clkOut, VECS[v].expOut);
      check($sformatf("R4 vec%0d drive", v), clkDrive, {10{VECS[v].oe}});
      @(negedge clkIn); #1;
      check($sformatf("R2 vec%0d low", v), clkOut, 10'h000);
    end
    oeIn = 1'b1;

    // R7 latency: change in low phase before edge k
    @(negedge clkIn); #0.5;
    setCfg(8'hFF, 8'hFF, 8'hFF);
    repeat (3) @(posedge clkIn);
    @(negedge clkIn); #0.5;
    setCfg(8'hFE, 8'hFF, 8'hFF);          // stop output 0
    @(posedge clkIn); #1;                  // edge k: still old
    check("R7 old behaviour at edge k", clkOut, 10'h3FF);
    @(posedge clkIn); #1;                  // edge k+1: new
    check("R7 new behaviour at edge k+1", clkOut, 10'h3FE);

    // R6: stop in the middle of a high phase must not shorten it
    @(negedge clkIn); #0.5;
    setCfg(8'hFF, 8'hFF, 8'hFF);
    repeat (3) @(posedge clkIn);
    #0.5;
    setCfg(8'hFF, 8'h0F, 8'hFF);          // stop outputs 4..7 mid-high
    #1;
    check("R6 high phase kept after mid-phase stop", clkOut, 10'h3FF);
    @(posedge clkIn); #1.5;
    check("R6 high phase kept one edge later", clkOut, 10'h3FF);
    @(posedge clkIn); #1;
    check("R6 stop lands on a whole phase", clkOut, 10'h30F);

    // R6: restart in the middle of a high phase must not raise the output
    @(posedge clkIn); #0.5;
    setCfg(8'hFF, 8'hFF, 8'hFF);
    #1;
    check("R6 no rise mid-phase on restart", clkOut, 10'h30F);
    @(posedge clkIn); #1.5;
    check("R6 still parked before gate load", clkOut, 10'h30F);
    @(posedge clkIn); #1;
    check("R6 restart on whole phase", clkOut, 10'h3FF);

    // R5: reset re-enables everything even with zero config
    @(negedge clkIn); #0.5;
    setCfg(8'h00, 8'h00, 8'h00);
    repeat (3) @(posedge clkIn); #1;
    check("R2 all stopped before reset", clkOut, 10'h000);
    @(negedge clkIn); #0.5;
    rstN = 1'b0;
    @(posedge clkIn); #1;
    check("R5 reset re-enables outputs", clkOut, 10'h3FF);
    @(negedge clkIn); #0.5;
    rstN = 1'b1;

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clkIn);
        chkCount++;
        errCount++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule